// File: doc/BRIEF.md
# Truth-Table One-Bit ALU

This block is the arithmetic and logic unit of a one-bit accumulator machine. A 4-bit opcode is decoded into a 4-entry truth table. A 4-to-1 selector then picks one entry of that table, using the data-bus bit and the accumulator bit as the select inputs. As a result, every two-input boolean function, including the constants, comes from the same selector rather than from a separate gate for each operation.

Besides the selector, the block holds a full adder and a single carry flag. An addition opcode sends the adder's sum to the result and stores the carry-out. Two forcing opcodes drive the result to a constant and also set or clear the flag. All other opcodes leave the flag alone. The flag only moves on a clock edge that has execute enable high. The result bit is purely combinational. The surrounding machine samples it into its accumulator, which lies outside this block.

Top module: `tt_alu1`

## Requirements
- R1: The result is entry `{data_bit, acc_bit}` of the decoded truth table, where that pair is read as a 2-bit index with `data_bit` as the MSB. A table written `t00 t01 t10 t11` gives result `t00` for data=0, acc=0, and result `t11` for data=1, acc=1.
- R2: The logic opcodes produce these results: 0x1 gives data; 0x2 gives NOT data; 0x7 gives XNOR; 0x8 gives XOR; 0x9 gives AND; 0xA gives OR.
- R3: Opcodes 0x0, 0x3, 0x4, 0x5, 0xD, 0xE and 0xF decode to the table `0 1 0 1`, so the result equals `acc_bit`.
- R4: Opcode 0x6 (add) gives a result equal to the XOR of `acc_bit`, `data_bit` and the current `carry`.
- R5: With opcode 0x6 and `exec_en` high, the carry after the next rising edge is the majority of `acc_bit`, `data_bit` and the previous `carry`.
- R6: Opcode 0xB gives result 1. With `exec_en` high, it clears the carry on the next rising edge.
- R7: Opcode 0xC gives result 0. With `exec_en` high, it sets the carry on the next rising edge.
- R8: Every opcode other than 0x6, 0xB and 0xC leaves the carry unchanged across an enabled edge.
- R9: When `exec_en` is low, the carry keeps its value for every opcode.
- R10: A synchronous reset (`rst` high at a rising edge) clears the carry. Reset takes priority over `exec_en`.
- R11: The result follows changes of `opcode`, `data_bit` and `acc_bit` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the carry flag updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the carry |
| exec_en | input | 1 | Lets the current opcode update the carry flag |
| opcode | input | 4 | Operation code |
| data_bit | input | 1 | Operand from the data bus |
| acc_bit | input | 1 | Operand from the accumulator |
| result | output | 1 | Combinational ALU result |
| carry | output | 1 | Current carry flag |

## Verification
The bench builds the block with its package defaults: a 2-bit select, a 4-entry table and a 4-bit opcode. These sizes are small enough to sweep the whole input space. Every opcode is run against all four operand pairs, with the carry preset to both 0 and 1 and with execute enable both high and low. This reaches every table entry and every carry action. Directed sequences cover the remaining cases: a chain of additions that ripples a carry, reset arriving together with a carry-setting opcode, and operand changes in the middle of a cycle.

// File: rtl/alu1_pkg.sv
package alu1_pkg;

    localparam int OPC_W = 4;
    localparam int SEL_W = 2;
    localparam int TT_W  = 1 << SEL_W;

    typedef enum logic [OPC_W-1:0] {
        OP_NOP       = 4'h0,
        OP_LOAD      = 4'h1,
        OP_LOAD_INV  = 4'h2,
        OP_STORE     = 4'h3,
        OP_STORE_INV = 4'h4,
        OP_OUT_EN    = 4'h5,
        OP_ADD       = 4'h6,
        OP_XNOR      = 4'h7,
        OP_XOR       = 4'h8,
        OP_AND       = 4'h9,
        OP_OR        = 4'hA,
        OP_SET_ONE   = 4'hB,
        OP_SET_TWO   = 4'hC,
        OP_JUMP      = 4'hD,
        OP_SKIP_Z    = 4'hE,
        OP_RETURN    = 4'hF
    } opcode_e;

    // table[i] is the output for select index i = {data, acc}
    typedef logic [TT_W-1:0] ttab_t;

    localparam ttab_t TT_ZERO  = 4'b0000;
    localparam ttab_t TT_ONE   = 4'b1111;
    localparam ttab_t TT_AND   = 4'b1000;
    localparam ttab_t TT_OR    = 4'b1110;
    localparam ttab_t TT_XOR   = 4'b0110;
    localparam ttab_t TT_XNOR  = 4'b1001;
    localparam ttab_t TT_DATA  = 4'b1100;
    localparam ttab_t TT_NDATA = 4'b0011;
    localparam ttab_t TT_ACC   = 4'b1010;

    typedef enum logic [1:0] {
        CA_KEEP  = 2'd0,
        CA_CLEAR = 2'd1,
        CA_SET   = 2'd2,
        CA_ADD   = 2'd3
    } carry_act_e;

    typedef struct packed {
        ttab_t      table_v;
        logic       use_sum;
        carry_act_e cact;
    } alu_ctrl_t;

endpackage

// File: rtl/alu1_decode.sv
module alu1_decode
    import alu1_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output alu_ctrl_t        ctrl
);
    opcode_e op;

    always_comb begin
        op = opcode_e'(opcode);
        ctrl.table_v = TT_ACC;
        ctrl.use_sum = 1'b0;
        ctrl.cact    = CA_KEEP;
        case (op)
            OP_LOAD:     ctrl.table_v = TT_DATA;
            OP_LOAD_INV: ctrl.table_v = TT_NDATA;
            OP_XNOR:     ctrl.table_v = TT_XNOR;
            OP_XOR:      ctrl.table_v = TT_XOR;
            OP_AND:      ctrl.table_v = TT_AND;
            OP_OR:       ctrl.table_v = TT_OR;
            OP_ADD: begin
                ctrl.table_v = TT_ZERO;
                ctrl.use_sum = 1'b1;
                ctrl.cact    = CA_ADD;
            end
            OP_SET_ONE: begin
                ctrl.table_v = TT_ONE;
                ctrl.cact    = CA_CLEAR;
            end
            OP_SET_TWO: begin
                ctrl.table_v = TT_ZERO;
                ctrl.cact    = CA_SET;
            end
            default:     ctrl.table_v = TT_ACC;
        endcase
    end
endmodule

// File: rtl/alu1_tt_select.sv
module alu1_tt_select #(
    parameter int SEL_W = 2,
    localparam int TT_W = 1 << SEL_W
) (
    input  logic [TT_W-1:0]  table_v,
    input  logic [SEL_W-1:0] sel,
    output logic             y
);
    // binary selection tree, one level per select bit
    logic [TT_W-1:0] lvl [SEL_W+1];

    assign lvl[0] = table_v;

    for (genvar l = 0; l < SEL_W; l++) begin : g_lvl
        localparam int N = TT_W >> (l + 1);
        for (genvar i = 0; i < TT_W; i++) begin : g_node
            if (i < N) begin : g_mux
                assign lvl[l+1][i] = sel[l] ? lvl[l][2*i+1] : lvl[l][2*i];
            end else begin : g_pad
                assign lvl[l+1][i] = 1'b0;
            end
        end
    end

    assign y = lvl[SEL_W][0];
endmodule

// File: rtl/alu1_full_add.sv
module alu1_full_add (
    input  logic a,
    input  logic b,
    input  logic cin,
    output logic sum,
    output logic cout
);
    logic half;

    always_comb begin
        half = a ^ b;
        sum  = half ^ cin;
        cout = (a & b) | (half & cin);
    end
endmodule

// File: rtl/alu1_carry_flag.sv
module alu1_carry_flag
    import alu1_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       exec_en,
    input  carry_act_e cact,
    input  logic       add_cout,
    output logic       carry_q
);
    typedef struct packed {
        logic carry;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.carry = 1'b0;
        end else if (exec_en) begin
            case (cact)
                CA_CLEAR: st_d.carry = 1'b0;
                CA_SET:   st_d.carry = 1'b1;
                CA_ADD:   st_d.carry = add_cout;
                default:  st_d.carry = st_q.carry;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign carry_q = st_q.carry;

    // R10: reset clears the flag whatever else is asserted
    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> !carry_q);

    // R9: no enable, no movement
    a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> (carry_q == $past(carry_q)));
endmodule

// File: rtl/tt_alu1.sv
module tt_alu1
    import alu1_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             exec_en,
    input  logic [OPC_W-1:0] opcode,
    input  logic             data_bit,
    input  logic             acc_bit,
    output logic             result,
    output logic             carry
);
    alu_ctrl_t  ctrl;
    logic       sel_y;
    logic       add_sum;
    logic       add_cout;
    logic       carry_q;

    alu1_decode u_dec (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    alu1_tt_select #(.SEL_W(SEL_W)) u_sel (
        .table_v (ctrl.table_v),
        .sel     ({data_bit, acc_bit}),
        .y       (sel_y)
    );

    alu1_full_add u_add (
        .a    (acc_bit),
        .b    (data_bit),
        .cin  (carry_q),
        .sum  (add_sum),
        .cout (add_cout)
    );

    alu1_carry_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .exec_en  (exec_en),
        .cact     (ctrl.cact),
        .add_cout (add_cout),
        .carry_q  (carry_q)
    );

    always_comb begin
        result = ctrl.use_sum ? add_sum : sel_y;
    end

    assign carry = carry_q;

    // R2: load passes the data bit through the selector
    a_r2_load_passes_data: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_LOAD) |-> (result == data_bit));

    // R3: control-only opcodes reproduce the accumulator
    a_r3_keep_acc: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_NOP || opcode == OP_JUMP || opcode == OP_STORE) |-> (result == acc_bit));

    // R4: add result is the three-way parity
    a_r4_add_sum: assert property (@(posedge clk) disable iff (rst)
        (opcode == OP_ADD) |-> (result == (acc_bit ^ data_bit ^ carry)));

    // R5: add writes the majority back
    a_r5_add_carry: assert property (@(posedge clk) disable iff (rst)
        (exec_en && opcode == OP_ADD) |=>
        (carry == (($past(acc_bit) & $past(data_bit)) |
                   ($past(carry) & ($past(acc_bit) | $past(data_bit))))));

    // R6: force one clears the flag
    a_r6_one_clears: assert property (@(posedge clk) disable iff (rst)
        (exec_en && opcode == OP_SET_ONE) |=> !carry);

    // R7: force zero sets the flag
    a_r7_two_sets: assert property (@(posedge clk) disable iff (rst)
        (exec_en && opcode == OP_SET_TWO) |=> carry);

    // R8: other opcodes keep the flag
    a_r8_keep_carry: assert property (@(posedge clk) disable iff (rst)
        (exec_en && opcode != OP_ADD && opcode != OP_SET_ONE && opcode != OP_SET_TWO)
        |=> (carry == $past(carry)));
endmodule

// File: tb/tb_tt_alu1.sv
`timescale 1ns/1ps
module tb_tt_alu1;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       exec_en = 1'b0;
    logic [3:0] opcode = 4'h0;
    logic       data_bit = 1'b0;
    logic       acc_bit = 1'b0;
    logic       result;
    logic       carry;

    int nchecks = 0;
    int nerr = 0;
    bit done = 1'b0;
    logic m_c = 1'b0;

    always #2.5 clk = ~clk;

    tt_alu1 dut (
        .clk      (clk),
        .rst      (rst),
        .exec_en  (exec_en),
        .opcode   (opcode),
        .data_bit (data_bit),
        .acc_bit  (acc_bit),
        .result   (result),
        .carry    (carry)
    );

    function automatic logic ref_result(logic [3:0] op, logic d, logic a, logic c);
        case (op)
            4'h1: return d;
            4'h2: return !d;
            4'h6: return d ^ a ^ c;
            4'h7: return !(d ^ a);
            4'h8: return d ^ a;
            4'h9: return d & a;
            4'hA: return d | a;
            4'hB: return 1'b1;
            4'hC: return 1'b0;
            default: return a;
        endcase
    endfunction

    function automatic string res_tag(logic [3:0] op);
        case (op)
            4'h6: return "R4";
            4'hB: return "R6";
            4'hC: return "R7";
            4'h1, 4'h2, 4'h7, 4'h8, 4'h9, 4'hA: return "R1 R2";
            default: return "R3";
        endcase
    endfunction

    function automatic string car_tag(logic r, logic e, logic [3:0] op);
        if (r) return "R10";
        if (!e) return "R9";
        case (op)
            4'h6: return "R5";
            4'hB: return "R6";
            4'hC: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, logic act, logic exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%b expected=%b (op=%h d=%b a=%b)",
                     tag, act, exp, opcode, data_bit, acc_bit);
        end
    endtask

    task automatic step(logic r, logic e, logic [3:0] op, logic d, logic a);
        @(negedge clk);
        rst = r; exec_en = e; opcode = op; data_bit = d; acc_bit = a;
        #1;
        if (!r) check(res_tag(op), result, ref_result(op, d, a, m_c));
        @(posedge clk);
        if (r) m_c = 1'b0;
        else if (e) begin
            case (op)
                4'h6: m_c = (d & a) | (m_c & (d | a));
                4'hB: m_c = 1'b0;
                4'hC: m_c = 1'b1;
                default: m_c = m_c;
            endcase
        end
        #1;
        check(car_tag(r, e, op), carry, m_c);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", nerr, nchecks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchecks++;
            nerr++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        // R10: reset state
        step(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 4'h0, 1'b0, 1'b0);

        // exhaustive sweep: opcode x carry preset x operands x enable
        for (int op = 0; op < 16; op++) begin
            for (int c = 0; c < 2; c++) begin
                for (int idx = 0; idx < 4; idx++) begin
                    for (int e = 0; e < 2; e++) begin
                        step(1'b0, 1'b1, (c != 0) ? 4'hC : 4'hB, 1'b0, 1'b0);
                        step(1'b0, e[0], op[3:0], idx[1], idx[0]);
                    end
                end
            end
        end

        // R5: ripple a carry through a chain of additions
        step(1'b0, 1'b1, 4'hB, 1'b0, 1'b0);
        step(1'b0, 1'b1, 4'h6, 1'b1, 1'b1);
        step(1'b0, 1'b1, 4'h6, 1'b1, 1'b0);
        step(1'b0, 1'b1, 4'h6, 1'b0, 1'b0);
        step(1'b0, 1'b1, 4'h6, 1'b0, 1'b1);

        // R10: reset wins over an enabled carry-setting opcode
        step(1'b0, 1'b1, 4'hC, 1'b0, 1'b0);
        step(1'b1, 1'b1, 4'hC, 1'b0, 1'b0);

        // R11: result tracks operand changes inside one cycle
        step(1'b0, 1'b0, 4'h9, 1'b0, 1'b0);
        @(negedge clk);
        exec_en = 1'b0; opcode = 4'h9; data_bit = 1'b1; acc_bit = 1'b1;
        #0.5;
        check("R11", result, 1'b1);
        acc_bit = 1'b0;
        #0.5;
        check("R11", result, 1'b0);
        opcode = 4'hA;
        #0.5;
        check("R11", result, 1'b1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule